// File: doc/BRIEF.md
# Converter Power-Mode Controller

This block turns two slow control levels, a power-down request and a converter enable, into one of three operating modes for a dual converter: active, standby or shutdown. The power-down request always wins. Each mode powers its own set of analog sub-circuits. The block drives separate enables for the reference, the control amplifier and the output current array.

It also drives the output stage. In standby the stage holds its last value. In shutdown it is parked, either pulled to ground or floated, depending on a build parameter. When the block returns to active, it counts a wake-up interval and only then raises a ready flag. The interval is short after standby and long after shutdown. Analog settling is modelled only as this cycle count.

The two control inputs are asynchronous levels. Each passes through a two-flop synchronizer before it is decoded. There is no data stream, so every pin is a plain level and none uses a handshake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: With the synchronized power-down request at 1, the mode is shutdown whatever the enable is. In shutdown the reference, amplifier and array enables are all 0.
- R2: With the power-down request at 0 and the enable at 0, the mode is standby. In standby the reference and amplifier enables are 1, the array enable is 0 and the hold output is 1.
- R3: With the power-down request at 0 and the enable at 1, the mode is active. In active all three enables are 1, and the hold and both park outputs are 0.
- R4: In shutdown, exactly one park output is 1. It is the ground output when PARK_GND is 1 and the high-impedance output when PARK_GND is 0. Outside shutdown both park outputs are 0.
- R5: A change on either control input reaches the mode outputs at the third rising clock edge after the change: two synchronizer stages, then the mode register.
- R6: On entry to active from standby, ready rises exactly STBY_WAKE_CYC rising edges after the edge at which the mode became active.
- R7: On entry to active from shutdown, ready rises exactly SHDN_WAKE_CYC rising edges after the edge at which the mode became active.
- R8: Ready is 0 in every mode except active, and it falls at the same edge at which the mode leaves active.
- R9: If the mode leaves active before the wake-up count expires, the count restarts on the next entry to active. The new count uses the length that belongs to the mode just left.
- R10: While reset is asserted, the mode is shutdown, ready is 0 and all three enables are 0. Both synchronizers reset to the shutdown request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwrdn_req_i | input | 1 | Power-down request level, asynchronous |
| conv_en_i | input | 1 | Converter enable level, asynchronous |
| ref_en_o | output | 1 | Reference enable |
| amp_en_o | output | 1 | Control amplifier enable |
| array_en_o | output | 1 | Output current array enable |
| out_hold_o | output | 1 | Output stage holds its last value |
| park_gnd_o | output | 1 | Output stage pulled to ground |
| park_hiz_o | output | 1 | Output stage floated |
| out_ready_o | output | 1 | Outputs valid after wake-up |

## Verification
The bench sweeps all sixteen pairs of input settings, from one settled state to another, and checks every output on every cycle against an arithmetic model of the three-edge latency and the wake-up count. A design that ignored the power-down priority would go active on the input setting 11. A design with one synchronizer stage too few or too many would change mode one edge early or late. A timer that took its length from the wrong mode would raise ready after the short count on leaving shutdown. A dedicated sequence breaks off a shutdown wake-up with a standby stay, which catches a counter that keeps running instead of reloading with the standby length.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_SHDN = 2'd0,
    MODE_STBY = 2'd1,
    MODE_ACT  = 2'd2
  } pwr_mode_e;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned             WIDTH   = 2,
  parameter int unsigned             STAGES  = 2,
  parameter logic [WIDTH-1:0]        RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
  import pwr_mode_pkg::*;
(
  input  logic      pwrdn_i,
  input  logic      en_i,
  output pwr_mode_e mode_o
);
  // power-down has priority over enable
  always_comb begin
    if (pwrdn_i)   mode_o = MODE_SHDN;
    else if (en_i) mode_o = MODE_ACT;
    else           mode_o = MODE_STBY;
  end
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer
  import pwr_mode_pkg::*;
#(
  parameter int unsigned STBY_WAKE_CYC = 20,
  parameter int unsigned SHDN_WAKE_CYC = 2000,
  localparam int unsigned CW = $clog2(SHDN_WAKE_CYC + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pwr_mode_e mode_q_i,
  input  pwr_mode_e mode_d_i,
  output logic      ready_o
);
  localparam logic [CW-1:0] STBY_LEN = CW'(STBY_WAKE_CYC);
  localparam logic [CW-1:0] SHDN_LEN = CW'(SHDN_WAKE_CYC);

  logic [CW-1:0] cnt_q;
  logic          entering;

  assign entering = (mode_d_i == MODE_ACT) && (mode_q_i != MODE_ACT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (entering) begin
      cnt_q <= (mode_q_i == MODE_STBY) ? STBY_LEN : SHDN_LEN;
    end else if (mode_q_i == MODE_ACT && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready_o = (mode_q_i == MODE_ACT) && (cnt_q == '0);
endmodule

// File: rtl/pwr_out_ctrl.sv
module pwr_out_ctrl
  import pwr_mode_pkg::*;
#(
  parameter bit PARK_GND = 1'b1
) (
  input  pwr_mode_e mode_i,
  output logic      ref_en_o,
  output logic      amp_en_o,
  output logic      array_en_o,
  output logic      hold_o,
  output logic      park_gnd_o,
  output logic      park_hiz_o
);
  logic parked;

  assign ref_en_o   = (mode_i != MODE_SHDN);
  assign amp_en_o   = (mode_i != MODE_SHDN);
  assign array_en_o = (mode_i == MODE_ACT);
  assign hold_o     = (mode_i == MODE_STBY);
  assign parked     = (mode_i == MODE_SHDN);

  generate
    if (PARK_GND) begin : g_park_gnd
      assign park_gnd_o = parked;
      assign park_hiz_o = 1'b0;
    end else begin : g_park_hiz
      assign park_gnd_o = 1'b0;
      assign park_hiz_o = parked;
    end
  endgenerate
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned STBY_WAKE_CYC = 20,
  parameter int unsigned SHDN_WAKE_CYC = 2000,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter bit          PARK_GND      = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrdn_req_i,
  input  logic conv_en_i,
  output logic ref_en_o,
  output logic amp_en_o,
  output logic array_en_o,
  output logic out_hold_o,
  output logic park_gnd_o,
  output logic park_hiz_o,
  output logic out_ready_o
);
  logic [1:0] ctl_sync;
  pwr_mode_e  mode_d, mode_q;

  // bit 1 = power-down (resets to 1), bit 0 = enable (resets to 0): R10
  pwr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({pwrdn_req_i, conv_en_i}),
    .sync_o (ctl_sync)
  );

  pwr_mode_decode u_dec (
    .pwrdn_i(ctl_sync[1]),
    .en_i   (ctl_sync[0]),
    .mode_o (mode_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_SHDN;
    else         mode_q <= mode_d;
  end

  pwr_wake_timer #(
    .STBY_WAKE_CYC(STBY_WAKE_CYC),
    .SHDN_WAKE_CYC(SHDN_WAKE_CYC)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_q_i(mode_q),
    .mode_d_i(mode_d),
    .ready_o (out_ready_o)
  );

  pwr_out_ctrl #(.PARK_GND(PARK_GND)) u_out (
    .mode_i    (mode_q),
    .ref_en_o  (ref_en_o),
    .amp_en_o  (amp_en_o),
    .array_en_o(array_en_o),
    .hold_o    (out_hold_o),
    .park_gnd_o(park_gnd_o),
    .park_hiz_o(park_hiz_o)
  );
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_en_o,
  input logic amp_en_o,
  input logic array_en_o,
  input logic out_hold_o,
  input logic park_gnd_o,
  input logic park_hiz_o,
  input logic out_ready_o
);
  assert_array_needs_bias_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    array_en_o |-> (ref_en_o && amp_en_o));

  assert_bias_together_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_en_o == amp_en_o);

  assert_park_only_unbiased_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (park_gnd_o || park_hiz_o) |-> (!ref_en_o && !out_hold_o));

  assert_one_stage_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({out_hold_o, park_gnd_o || park_hiz_o, array_en_o}));

  assert_ready_only_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ready_o |-> array_en_o);

  assert_wake_not_instant_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(array_en_o) |-> !out_ready_o);

  assert_ready_after_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_ready_o) |-> $past(array_en_o));
endmodule

bind pwr_mode_ctrl pwr_mode_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ref_en_o   (ref_en_o),
  .amp_en_o   (amp_en_o),
  .array_en_o (array_en_o),
  .out_hold_o (out_hold_o),
  .park_gnd_o (park_gnd_o),
  .park_hiz_o (park_hiz_o),
  .out_ready_o(out_ready_o)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
  localparam int STBY = 4;
  localparam int SHDN = 10;
  localparam int OBS  = 3 + SHDN + 4;
  // model mode codes: 0 shutdown, 1 standby, 2 active
  localparam int M_SH = 0, M_SB = 1, M_AC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd = 1'b1, en = 1'b0;
  logic ref_en, amp_en, arr_en, hold, pgnd, phiz, rdy;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(
    .STBY_WAKE_CYC(STBY), .SHDN_WAKE_CYC(SHDN), .SYNC_STAGES(2), .PARK_GND(1'b1)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwrdn_req_i(pd), .conv_en_i(en),
    .ref_en_o(ref_en), .amp_en_o(amp_en), .array_en_o(arr_en), .out_hold_o(hold),
    .park_gnd_o(pgnd), .park_hiz_o(phiz), .out_ready_o(rdy)
  );

  function automatic int mode_of(input int code);
    if (code[1]) return M_SH;   // R1: pd priority
    if (code[0]) return M_AC;   // R3
    return M_SB;                // R2
  endfunction

  function automatic int wake_of(input int m);
    return (m == M_SB) ? STBY : SHDN;
  endfunction

  // {ref, amp, array, hold, pgnd, phiz, ready}
  function automatic logic [6:0] expect_vec(input int m, input bit r);
    case (m)
      M_SH:    return 7'b0000100;
      M_SB:    return 7'b1101000;
      default: return {6'b111000, r};
    endcase
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {ref_en, amp_en, arr_en, hold, pgnd, phiz, rdy};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic apply(input int code);
    pd = code[1];
    en = code[0];
  endtask

  task automatic settle(input int code);
    apply(code);
    repeat (OBS + 5) @(negedge clk);
  endtask

  // observe one step after a change, starting just after the drive at a negedge
  task automatic sweep_step(input int from_c, input int to_c);
    int om, nm, em;
    bit er;
    om = mode_of(from_c);
    nm = mode_of(to_c);
    apply(to_c);
    for (int i = 1; i <= OBS; i++) begin
      @(negedge clk);
      em = (i >= 3) ? nm : om;                  // R5 latency
      if (em != M_AC) er = 1'b0;                // R8
      else if (om == M_AC) er = 1'b1;
      else er = (i >= 3 + wake_of(om));         // R6 / R7
      check((em == M_AC && om != M_AC) ? ((om == M_SB) ? "R6" : "R7") :
            (i < 3 && nm != om) ? "R5" :
            (em == M_SH) ? "R1/R4" : (em == M_SB) ? "R2" : "R3", expect_vec(em, er));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", expect_vec(M_SH, 1'b0));
    apply(2'b01);
    repeat (3) @(negedge clk);
    check("R10", expect_vec(M_SH, 1'b0));
    apply(2'b10);
    rst_n = 1'b1;

    // exhaustive from/to sweep of {pd,en}
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        settle(f);
        check("R1/R2/R3", expect_vec(mode_of(f), mode_of(f) == M_AC));
        sweep_step(f, t);
      end
    end

    // R9: shutdown wake broken off by standby, then resumed from standby
    settle(2'b10);
    apply(2'b01);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      check("R9", expect_vec(i >= 3 ? M_AC : M_SH, 1'b0));
    end
    apply(2'b00);
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      check("R9", expect_vec(i >= 3 ? M_SB : M_AC, 1'b0));
    end
    apply(2'b01);
    for (int i = 1; i <= 3 + SHDN; i++) begin
      @(negedge clk);
      check("R9", expect_vec(i >= 3 ? M_AC : M_SB, i >= 3 + STBY));
    end

    // R10: reset in the middle of active operation
    apply(2'b01);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10", expect_vec(M_SH, 1'b0));
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 1; i <= 3 + SHDN + 1; i++) begin
      @(negedge clk);
      check("R10", expect_vec(i >= 3 ? M_AC : M_SH, i >= 3 + SHDN));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule